// File: doc/BRIEF.md
# Interrupt Acknowledge Responder

This block is the device side of a prioritized interrupt handshake. Device logic raises a request at a chosen priority level; the block holds it and presents that level on the request lines toward the processor. When the processor runs an acknowledge cycle, it puts the level it is serving on address bits 3 to 1. The block compares that level with its own, and answers only when they match.

The block answers in one of two ways, chosen by a configuration input. In vector mode it places an 8-bit vector number on data bits 7 to 0 and asserts the transfer acknowledge. In fallback mode it asserts the valid-peripheral-address signal instead, and leaves the data lines alone. The processor then forms the vector number itself as 0x18 plus the level, which gives 0x19 through 0x1F. The request is cleared when the processor ends the acknowledge cycle for its level.

Top module: `irq_vec_responder`

## Requirements
- R1: After reset, ipl_o is 0 and data_o, data_oe_o, dtack_o and vpa_o are all 0.
- R2: A raise_i pulse with a nonzero raise_lvl_i makes ipl_o show that level from the next cycle on. A raise with level 0 makes no request, and ipl_o stays 0.
- R3: While a request is pending, a raise at a higher level replaces the held level. A raise at an equal or lower level leaves it unchanged.
- R4: In vector mode (vec_en_i=1), iack_i high with ack_addr_i (address bits 3:1) equal to a nonzero ipl_o gives, one cycle later, dtack_o=1, data_oe_o=1 and data_o equal to the vector_i sampled at that match.
- R5: In fallback mode (vec_en_i=0), the same match gives vpa_o=1 with dtack_o=0, data_oe_o=0 and data_o=0. The processor-side vector number is then 0x18 plus the level.
- R6: An acknowledge whose level differs from ipl_o, or one that comes while nothing is pending, drives none of dtack_o, vpa_o or data_oe_o, and the pending request stays as it was.
- R7: The response holds while iack_i stays high. In the cycle after iack_i falls, every response output returns to 0 and ipl_o goes to 0. A raise presented in that same cycle arms a fresh request at its own level.
- R8: dtack_o and vpa_o are never 1 together, and data_oe_o is never 1 without dtack_o.
- R9: The mode and the vector are captured when the response starts. Changes to vec_en_i or vector_i during the response have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 1 | One-cycle pulse that raises a request |
| raise_lvl_i | input | LVL_W | Priority level of the raise (0 = none) |
| vec_en_i | input | 1 | 1: the device supplies the vector; 0: fallback to the processor-formed vector |
| vector_i | input | VEC_W | Vector number used in vector mode |
| iack_i | input | 1 | Acknowledge cycle in progress |
| ack_addr_i | input | LVL_W | Level being acknowledged (address bits 3:1) |
| ipl_o | output | LVL_W | Request level toward the processor, 0 when idle |
| data_o | output | VEC_W | Vector number on data bits 7:0 |
| data_oe_o | output | 1 | Data bus drive enable |
| dtack_o | output | 1 | Transfer acknowledge |
| vpa_o | output | 1 | Valid-peripheral-address (fallback) request |

## Verification
The bench builds the block with its defaults: a 3-bit level and an 8-bit vector. With these values every nonzero level, 1 through 7, can be raised and acknowledged. Every fallback vector number from 0x19 to 0x1F can also be reached. A full vector byte, including values with the top bit set, is checked in vector mode. Preemption, mismatched levels, mid-response configuration changes and re-arming in the completion cycle are each driven on purpose.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  typedef enum logic {
    RS_IDLE,
    RS_ACTIVE
  } rsp_state_e;
endpackage

// File: rtl/irq_req_hold.sv
module irq_req_hold #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_i,
  input  logic [LVL_W-1:0] raise_lvl_i,
  input  logic             clear_i,
  output logic             pend_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic             pend_q;
  logic [LVL_W-1:0] lvl_q;
  logic             raise_ok;

  assign raise_ok = raise_i && (raise_lvl_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
    end else if (raise_ok) begin
      // a clear in the same cycle lets the new raise re-arm at its own level
      if (!pend_q || clear_i || (raise_lvl_i > lvl_q)) lvl_q <= raise_lvl_i;
      pend_q <= 1'b1;
    end else if (clear_i) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
    end
  end

  assign pend_o = pend_q;
  assign lvl_o  = pend_q ? lvl_q : '0;
endmodule

// File: rtl/iack_decode.sv
module iack_decode #(
  parameter int LVL_W = 3
) (
  input  logic             iack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             pend_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             hit_o
);
  assign hit_o = iack_i && pend_i && (lvl_i != '0) && (ack_lvl_i == lvl_i);
endmodule

// File: rtl/iack_resp.sv
module iack_resp
  import irq_resp_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             iack_i,
  input  logic             vec_en_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic             done_o,
  output logic [VEC_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             dtack_o,
  output logic             vpa_o
);
  rsp_state_e       state_q;
  logic             mode_vec_q;
  logic [VEC_W-1:0] vec_q;
  logic             active;

  assign active = (state_q == RS_ACTIVE);
  assign done_o = active && !iack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RS_IDLE;
      mode_vec_q <= 1'b0;
      vec_q      <= '0;
    end else begin
      case (state_q)
        RS_IDLE: if (hit_i) begin
          state_q    <= RS_ACTIVE;
          mode_vec_q <= vec_en_i;
          vec_q      <= vector_i;
        end
        RS_ACTIVE: if (!iack_i) state_q <= RS_IDLE;
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign dtack_o   = active && mode_vec_q;
  assign data_oe_o = active && mode_vec_q;
  assign vpa_o     = active && !mode_vec_q;
  assign data_o    = (active && mode_vec_q) ? vec_q : '0;
endmodule

// File: rtl/irq_vec_responder.sv
module irq_vec_responder #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_i,
  input  logic [LVL_W-1:0] raise_lvl_i,
  input  logic             vec_en_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             iack_i,
  input  logic [LVL_W-1:0] ack_addr_i,
  output logic [LVL_W-1:0] ipl_o,
  output logic [VEC_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             dtack_o,
  output logic             vpa_o
);
  logic             pend;
  logic [LVL_W-1:0] lvl;
  logic             hit;
  logic             done;

  irq_req_hold #(.LVL_W(LVL_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raise_i    (raise_i),
    .raise_lvl_i(raise_lvl_i),
    .clear_i    (done),
    .pend_o     (pend),
    .lvl_o      (lvl)
  );

  iack_decode #(.LVL_W(LVL_W)) u_dec (
    .iack_i   (iack_i),
    .ack_lvl_i(ack_addr_i),
    .pend_i   (pend),
    .lvl_i    (lvl),
    .hit_o    (hit)
  );

  iack_resp #(.VEC_W(VEC_W)) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .iack_i   (iack_i),
    .vec_en_i (vec_en_i),
    .vector_i (vector_i),
    .done_o   (done),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .dtack_o  (dtack_o),
    .vpa_o    (vpa_o)
  );

  assign ipl_o = lvl;
endmodule

// File: rtl/irq_vec_responder_chk.sv
module irq_vec_responder_chk #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             raise_i,
  input logic             vec_en_i,
  input logic [VEC_W-1:0] vector_i,
  input logic             iack_i,
  input logic [LVL_W-1:0] ack_addr_i,
  input logic [LVL_W-1:0] ipl_o,
  input logic [VEC_W-1:0] data_o,
  input logic             data_oe_o,
  input logic             dtack_o,
  input logic             vpa_o
);
  logic rsp;
  assign rsp = dtack_o || vpa_o;

  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dtack_o && vpa_o));

  a_r8_oe_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> dtack_o);

  a_r4_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsp && iack_i && ipl_o != '0 && ack_addr_i == ipl_o && vec_en_i)
    |=> (dtack_o && data_oe_o && data_o == $past(vector_i)));

  a_r5_autovec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsp && iack_i && ipl_o != '0 && ack_addr_i == ipl_o && !vec_en_i)
    |=> (vpa_o && !dtack_o && !data_oe_o));

  a_r6_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp && !$past(rsp)) |-> ($past(iack_i) && $past(ipl_o) != '0
                              && $past(ack_addr_i) == $past(ipl_o)));

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp && !iack_i && !raise_i) |=> (!rsp && !data_oe_o && ipl_o == '0));

  a_r9_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp && iack_i) |=> ($stable(data_o) && $stable(dtack_o) && $stable(vpa_o)));
endmodule

bind irq_vec_responder irq_vec_responder_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .raise_i   (raise_i),
  .vec_en_i  (vec_en_i),
  .vector_i  (vector_i),
  .iack_i    (iack_i),
  .ack_addr_i(ack_addr_i),
  .ipl_o     (ipl_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .dtack_o   (dtack_o),
  .vpa_o     (vpa_o)
);

// File: tb/irq_vec_responder_tb.sv
`timescale 1ns/1ps
module irq_vec_responder_tb;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             raise = 1'b0;
  logic [LVL_W-1:0] raise_lvl = '0;
  logic             vec_en = 1'b0;
  logic [VEC_W-1:0] vector = '0;
  logic             iack = 1'b0;
  logic [LVL_W-1:0] ack_addr = '0;
  logic [LVL_W-1:0] ipl;
  logic [VEC_W-1:0] data;
  logic             data_oe, dtack, vpa;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit rsp_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_responder #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .raise_lvl_i(raise_lvl),
    .vec_en_i(vec_en), .vector_i(vector), .iack_i(iack), .ack_addr_i(ack_addr),
    .ipl_o(ipl), .data_o(data), .data_oe_o(data_oe), .dtack_o(dtack), .vpa_o(vpa)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_raise(input int lvl);
    @(negedge clk);
    raise = 1'b1; raise_lvl = LVL_W'(lvl);
    @(negedge clk);
    raise = 1'b0; raise_lvl = '0;
  endtask

  // driver: pushes the processor-side vector number expected for a matching ack
  task automatic do_ack(input int lvl, input bit ven, input int vec, input bit match);
    int ipl0;
    int d0;
    @(negedge clk);
    ipl0 = int'(ipl);
    ack_addr = LVL_W'(lvl); vec_en = ven; vector = VEC_W'(vec); iack = 1'b1;
    if (match) exp_q.push_back(ven ? vec : 32'h18 + lvl);
    @(negedge clk);
    if (!match) begin
      chk("R6 dtack", int'(dtack), 0);
      chk("R6 vpa", int'(vpa), 0);
      chk("R6 data_oe", int'(data_oe), 0);
    end else if (ven) begin
      chk("R4 dtack", int'(dtack), 1);
      chk("R4 data_oe", int'(data_oe), 1);
    end else begin
      chk("R5 vpa", int'(vpa), 1);
      chk("R5 data_oe", int'(data_oe), 0);
      chk("R5 data", int'(data), 0);
    end
    d0 = int'(data);
    vec_en = ~ven; vector = ~VEC_W'(vec);
    @(negedge clk);
    if (match) begin
      chk("R9 data held", int'(data), d0);
      chk("R9 mode held", int'(vpa), ven ? 0 : 1);
    end
    iack = 1'b0;
    @(negedge clk);
    chk("R7 release", int'(dtack | vpa | data_oe), 0);
    chk(match ? "R7 ipl cleared" : "R6 pending kept", int'(ipl), match ? 0 : ipl0);
  endtask

  // monitor: pops the scoreboard when a response starts
  always @(negedge clk) begin
    if (rst_n) begin
      bit rsp;
      int obs;
      rsp = dtack || vpa;
      if (rsp) begin
        chk("R8 exclusive", int'(dtack && vpa), 0);
        chk("R8 oe with ack", int'(data_oe && !dtack), 0);
      end
      if (rsp && !rsp_prev) begin
        obs = vpa ? 32'h18 + int'(ack_addr) : int'(data);
        if (exp_q.size() == 0) chk("R6 unexpected response", 1, 0);
        else chk(vpa ? "R5 vector number" : "R4 vector number", obs, exp_q.pop_front());
      end
      rsp_prev = rsp;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ipl", int'(ipl), 0);
    chk("R1 outputs", int'({data, data_oe, dtack, vpa}), 0);

    do_raise(0);
    chk("R2 level 0 ignored", int'(ipl), 0);
    do_raise(3);
    chk("R2 ipl", int'(ipl), 3);
    do_raise(1);
    chk("R3 lower kept", int'(ipl), 3);
    do_raise(5);
    chk("R3 preempt", int'(ipl), 5);

    do_ack(3, 1'b1, 8'h40, 1'b0);      // R6 mismatch
    do_ack(5, 1'b1, 8'h40, 1'b1);      // R4 + R9 + R7
    do_ack(2, 1'b1, 8'h33, 1'b0);      // R6 nothing pending

    do_raise(7);
    do_ack(7, 1'b0, 8'hAA, 1'b1);      // R5 -> 0x1F
    do_raise(1);
    do_ack(1, 1'b0, 8'h00, 1'b1);      // R5 -> 0x19

    for (int l = 1; l < 8; l++) begin
      do_raise(l);
      do_ack(l, 1'b1, 8'h80 + l, 1'b1); // R4 every level
    end

    // R7 re-arm in the completion cycle
    do_raise(4);
    @(negedge clk);
    ack_addr = 3'd4; vec_en = 1'b1; vector = 8'h5C; iack = 1'b1;
    exp_q.push_back(8'h5C);
    @(negedge clk);
    @(negedge clk);
    iack = 1'b0; raise = 1'b1; raise_lvl = 3'd2;
    @(negedge clk);
    raise = 1'b0; raise_lvl = '0;
    chk("R7 rearm outputs", int'(dtack | vpa | data_oe), 0);
    chk("R7 rearm ipl", int'(ipl), 2);

    repeat (2) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule